// File: doc/BRIEF.md
# Encoder Control Register File

A memory-mapped register bank with an AXI4-Lite slave port (32-bit data) that sits next to a frame-based image encoder. Software uses it to turn the encoder on, to pulse a soft reset into the core, to choose a quality factor and a restart interval, and to read back the core's state: whether the core is busy, whether a frame has finished since the last acknowledge, how many frames have finished, and how many bytes the last finished frame used.

The core drives three side-band inputs. `core_busy` is a live level. `frame_start` is a one-cycle pulse at the start of each frame. `frame_end` is a one-cycle pulse at the end of each frame, with the byte total of that frame on `frame_bytes`. The quality and restart values the core actually uses, `quality_o` and `restart_o`, are copies of the software registers. These copies change only on a `frame_start` pulse, so a frame is never coded with mixed settings. Writes are whole-word, and byte strobes are not used. At most one read and one write transaction are in flight at a time.

Top module: `enc_ctrl_regs`

## Requirements
- R1: After reset, `awready`, `wready`, `bvalid`, `arready`, `rvalid`, `enable_o` and `soft_rst_o` are low. Control, status, frame count, restart and frame size read 0. Quality reads 95, and `quality_o` is 95 and `restart_o` is 0.
- R2: A write is accepted once `awvalid` and `wvalid` are both high. `awready` and `wready` then rise together for exactly one cycle. In the next cycle `bvalid` rises with `bresp` = 0 (OKAY) and stays high until `bready` is seen.
- R3: A read raises `arready` for one cycle. In the next cycle `rvalid` rises with `rresp` = 0, and `rvalid` and `rdata` stay unchanged until `rready` is seen.
- R4: Offset 0x00 bit 0 is the enable bit. It can be read and written, and it drives `enable_o` from the cycle after the write handshake.
- R5: Writing 1 to offset 0x00 bit 1 gives `soft_rst_o` a single-cycle pulse in the cycle after the handshake. Bit 1 always reads 0. The same write clears frame-done, the frame count and the frame size, and leaves quality, restart and enable as written.
- R6: A `frame_end` pulse sets frame-done, increments the frame count (offset 0x08) and captures `frame_bytes` into the frame size (offset 0x14), all at the same clock edge.
- R7: Offset 0x04 bit 1 is frame-done. Writing 1 to it clears it and writing 0 leaves it. If a `frame_end` pulse arrives at the same edge as the clear, the bit stays set. Bit 0 shows `core_busy` live, and writes do not change it.
- R8: A write to the quality register (offset 0x0C) stores 1 when the data is 0, stores 100 when the unsigned data is above 100, and otherwise stores the data as written.
- R9: `quality_o` and `restart_o` take the register values only at a `frame_start` pulse. At any other time they hold.
- R10: The restart interval register (offset 0x10) keeps the low RINT_W (16) bits of a write and reads back zero-extended. 0 means restarts are off.
- R11: Reads from offsets outside 0x00 to 0x14 return 0 with OKAY. Writes to those offsets change no register.
- R12: Writes to the frame count (0x08) and the frame size (0x14) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| awaddr | input | ADDR_W (8) | Write address |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| wdata | input | 32 | Write data |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| bresp | output | 2 | Write response, always OKAY |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| araddr | input | ADDR_W (8) | Read address |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| rdata | output | 32 | Read data |
| rresp | output | 2 | Read response, always OKAY |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| core_busy | input | 1 | Core busy level |
| frame_start | input | 1 | Start-of-frame pulse |
| frame_end | input | 1 | End-of-frame pulse |
| frame_bytes | input | 32 | Byte count of the frame ending now |
| enable_o | output | 1 | Encoder enable |
| soft_rst_o | output | 1 | One-cycle soft reset pulse |
| quality_o | output | 7 | Quality factor used for the current frame |
| restart_o | output | RINT_W (16) | Restart interval used for the current frame |

## Verification
The hardest case to reach is a frame-done clear that lands on the same edge as a `frame_end` pulse. The edge of a write is set by the slave's ready timing, not by the master. To reach it, the bench holds the write valids and waits for `awready`, then raises `frame_end` in that half cycle, so both events meet at the handshake edge. Response stalls are produced by holding `bready` and `rready` low for several cycles. A reference model in the bench tracks every register and the staged outputs, and the outputs are compared against it on every falling edge.

// File: rtl/enc_ctrl_pkg.sv
package enc_ctrl_pkg;
  // Register offsets (byte addresses)
  localparam int OFF_CTRL  = 'h00;
  localparam int OFF_STAT  = 'h04;
  localparam int OFF_FCNT  = 'h08;
  localparam int OFF_QUAL  = 'h0C;
  localparam int OFF_RINT  = 'h10;
  localparam int OFF_FSIZE = 'h14;

  localparam int QW    = 7;
  localparam int Q_MIN = 1;
  localparam int Q_MAX = 100;
  localparam int Q_RST = 95;

  localparam logic [1:0] RESP_OK = 2'b00;

  function automatic logic [QW-1:0] clamp_q(input logic [31:0] v);
    if (v < 32'(Q_MIN))      return QW'(Q_MIN);
    else if (v > 32'(Q_MAX)) return QW'(Q_MAX);
    else                     return v[QW-1:0];
  endfunction
endpackage

// File: rtl/enc_ctrl_axil.sv
module enc_ctrl_axil
  import enc_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wvalid,
  output logic              wready,
  output logic [1:0]        bresp,
  output logic              bvalid,
  input  logic              bready,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rvalid,
  input  logic              rready,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i
);
  logic              aw_rdy, b_vld, ar_rdy, r_vld;
  logic [DATA_W-1:0] r_dat;
  logic              rd_en;

  assign wr_en_o   = aw_rdy && awvalid && wvalid;
  assign wr_addr_o = awaddr;
  assign wr_data_o = wdata;
  assign rd_en     = ar_rdy && arvalid;
  assign rd_addr_o = araddr;

  always_ff @(posedge clk) begin
    if (rst) begin
      aw_rdy <= 1'b0;
      b_vld  <= 1'b0;
      ar_rdy <= 1'b0;
      r_vld  <= 1'b0;
      r_dat  <= '0;
    end else begin
      aw_rdy <= !aw_rdy && !b_vld && awvalid && wvalid;
      if (wr_en_o)             b_vld <= 1'b1;
      else if (b_vld && bready) b_vld <= 1'b0;
      ar_rdy <= !ar_rdy && !r_vld && arvalid;
      if (rd_en) begin
        r_vld <= 1'b1;
        r_dat <= rd_data_i;
      end else if (r_vld && rready) begin
        r_vld <= 1'b0;
      end
    end
  end

  assign awready = aw_rdy;
  assign wready  = aw_rdy;
  assign bvalid  = b_vld;
  assign bresp   = RESP_OK;
  assign arready = ar_rdy;
  assign rvalid  = r_vld;
  assign rdata   = r_dat;
  assign rresp   = RESP_OK;

  // R2
  aw_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    awready |=> !awready);
  // R2
  b_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bvalid && !bready |=> bvalid);
  // R3
  r_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rvalid && !rready |=> rvalid && $stable(rdata));
endmodule

// File: rtl/enc_ctrl_bank.sv
module enc_ctrl_bank
  import enc_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int RINT_W = 16,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              core_busy,
  input  logic              frame_start,
  input  logic              frame_end,
  input  logic [DATA_W-1:0] frame_bytes,
  output logic              enable_o,
  output logic              soft_rst_o,
  output logic [QW-1:0]     quality_o,
  output logic [RINT_W-1:0] restart_o
);
  logic              en_q, soft_q, done_q;
  logic [CNT_W-1:0]  fcnt_q;
  logic [DATA_W-1:0] fsize_q;
  logic [QW-1:0]     qual_q, qual_act;
  logic [RINT_W-1:0] rint_q, rint_act;

  logic hit_ctrl, hit_stat, hit_qual, hit_rint, soft_clr;
  assign hit_ctrl = wr_en && (wr_addr == ADDR_W'(OFF_CTRL));
  assign hit_stat = wr_en && (wr_addr == ADDR_W'(OFF_STAT));
  assign hit_qual = wr_en && (wr_addr == ADDR_W'(OFF_QUAL));
  assign hit_rint = wr_en && (wr_addr == ADDR_W'(OFF_RINT));
  assign soft_clr = hit_ctrl && wr_data[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      soft_q   <= 1'b0;
      done_q   <= 1'b0;
      fcnt_q   <= '0;
      fsize_q  <= '0;
      qual_q   <= QW'(Q_RST);
      rint_q   <= '0;
      qual_act <= QW'(Q_RST);
      rint_act <= '0;
    end else begin
      soft_q <= soft_clr;
      if (hit_ctrl) en_q   <= wr_data[0];
      if (hit_qual) qual_q <= clamp_q(32'(wr_data));
      if (hit_rint) rint_q <= wr_data[RINT_W-1:0];
      if (frame_start) begin
        qual_act <= qual_q;
        rint_act <= rint_q;
      end
      if (soft_clr) begin
        done_q  <= 1'b0;
        fcnt_q  <= '0;
        fsize_q <= '0;
      end else if (frame_end) begin
        done_q  <= 1'b1;
        fcnt_q  <= fcnt_q + 1'b1;
        fsize_q <= frame_bytes;
      end else if (hit_stat && wr_data[1]) begin
        done_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_W'(OFF_CTRL):  rd_data = DATA_W'(en_q);
      ADDR_W'(OFF_STAT):  rd_data = DATA_W'({done_q, core_busy});
      ADDR_W'(OFF_FCNT):  rd_data = DATA_W'(fcnt_q);
      ADDR_W'(OFF_QUAL):  rd_data = DATA_W'(qual_q);
      ADDR_W'(OFF_RINT):  rd_data = DATA_W'(rint_q);
      ADDR_W'(OFF_FSIZE): rd_data = fsize_q;
      default:            rd_data = '0;
    endcase
  end

  assign enable_o   = en_q;
  assign soft_rst_o = soft_q;
  assign quality_o  = qual_act;
  assign restart_o  = rint_act;

  // R8
  q_range_chk: assert property (@(posedge clk) disable iff (rst)
    qual_q >= QW'(Q_MIN) && qual_q <= QW'(Q_MAX));
  // R5
  soft_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst_o |=> !soft_rst_o);
  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    frame_end && !soft_clr |=> fcnt_q == $past(fcnt_q) + 1'b1);
  // R7
  done_set_chk: assert property (@(posedge clk) disable iff (rst)
    frame_end && !soft_clr |=> done_q);
  // R9
  q_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(quality_o) && $stable(restart_o));
endmodule

// File: rtl/enc_ctrl_regs.sv
module enc_ctrl_regs
  import enc_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int RINT_W = 16,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [31:0]       wdata,
  input  logic              wvalid,
  output logic              wready,
  output logic [1:0]        bresp,
  output logic              bvalid,
  input  logic              bready,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [31:0]       rdata,
  output logic [1:0]        rresp,
  output logic              rvalid,
  input  logic              rready,
  input  logic              core_busy,
  input  logic              frame_start,
  input  logic              frame_end,
  input  logic [31:0]       frame_bytes,
  output logic              enable_o,
  output logic              soft_rst_o,
  output logic [6:0]        quality_o,
  output logic [RINT_W-1:0] restart_o
);
  localparam int DATA_W = 32;

  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;

  enc_ctrl_axil #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_axil (
    .clk(clk), .rst(rst),
    .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
    .wdata(wdata), .wvalid(wvalid), .wready(wready),
    .bresp(bresp), .bvalid(bvalid), .bready(bready),
    .araddr(araddr), .arvalid(arvalid), .arready(arready),
    .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  enc_ctrl_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RINT_W(RINT_W), .CNT_W(CNT_W)) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .core_busy(core_busy), .frame_start(frame_start),
    .frame_end(frame_end), .frame_bytes(frame_bytes),
    .enable_o(enable_o), .soft_rst_o(soft_rst_o),
    .quality_o(quality_o), .restart_o(restart_o)
  );
endmodule

// File: tb/enc_ctrl_regs_test.sv
module enc_ctrl_regs_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  awaddr = '0, araddr = '0;
  logic        awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
  logic [31:0] wdata = '0, frame_bytes = '0;
  logic        core_busy = 0, frame_start = 0, frame_end = 0;
  logic        awready, wready, bvalid, arready, rvalid, enable_o, soft_rst_o;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;
  logic [6:0]  quality_o;
  logic [15:0] restart_o;

  int n_chk = 0, n_fail = 0;

  // reference model
  bit          m_en, m_soft, m_done;
  int unsigned m_cnt, m_size, m_qual, m_rint, m_qo, m_ro;

  enc_ctrl_regs uut (
    .clk(clk), .rst(rst),
    .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
    .wdata(wdata), .wvalid(wvalid), .wready(wready),
    .bresp(bresp), .bvalid(bvalid), .bready(bready),
    .araddr(araddr), .arvalid(arvalid), .arready(arready),
    .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready),
    .core_busy(core_busy), .frame_start(frame_start),
    .frame_end(frame_end), .frame_bytes(frame_bytes),
    .enable_o(enable_o), .soft_rst_o(soft_rst_o),
    .quality_o(quality_o), .restart_o(restart_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h00: return {31'd0, m_en};
      8'h04: return {30'd0, m_done, core_busy};
      8'h08: return m_cnt;
      8'h0C: return m_qual;
      8'h10: return m_rint;
      8'h14: return m_size;
      default: return 32'd0;
    endcase
  endfunction

  function automatic void model_reset();
    m_en = 0; m_soft = 0; m_done = 0; m_cnt = 0; m_size = 0;
    m_qual = 95; m_rint = 0; m_qo = 95; m_ro = 0;
  endfunction

  // per-cycle comparison of the control outputs (R4, R5, R9)
  always @(negedge clk) begin
    if (!rst) begin
      chk("R4 enable_o", {31'd0, enable_o}, {31'd0, m_en});
      chk("R5 soft_rst_o", {31'd0, soft_rst_o}, {31'd0, m_soft});
      chk("R9 quality_o", {25'd0, quality_o}, m_qo);
      chk("R9 restart_o", {16'd0, restart_o}, m_ro);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit with_end,
                    input logic [31:0] bytes, input int bhold);
    @(negedge clk);
    awaddr = a; wdata = d; awvalid = 1; wvalid = 1; bready = (bhold == 0);
    do @(negedge clk); while (!awready);
    chk("R2 wready with awready", {31'd0, wready}, 32'd1);
    if (with_end) begin frame_end = 1; frame_bytes = bytes; end
    @(posedge clk);
    if (with_end) begin m_done = 1; m_cnt++; m_size = bytes; end
    case (a)
      8'h00: begin m_en = d[0]; m_soft = d[1];
                   if (d[1]) begin m_done = 0; m_cnt = 0; m_size = 0; end end
      8'h04: if (d[1] && !with_end) m_done = 0;
      8'h0C: m_qual = (d == 0) ? 1 : (d > 100) ? 100 : d;
      8'h10: m_rint = {16'd0, d[15:0]};
      default: ;
    endcase
    #1 awvalid = 0; wvalid = 0; frame_end = 0;
    @(negedge clk);
    chk("R2 bvalid", {31'd0, bvalid}, 32'd1);
    chk("R2 bresp", {30'd0, bresp}, 32'd0);
    chk("R2 awready one cycle", {31'd0, awready}, 32'd0);
    for (int i = 0; i < bhold; i++) begin
      @(posedge clk); m_soft = 0;
      @(negedge clk);
      chk("R2 bvalid held", {31'd0, bvalid}, 32'd1);
    end
    bready = 1;
    @(posedge clk); m_soft = 0;
    @(negedge clk);
    chk("R2 bvalid drop", {31'd0, bvalid}, 32'd0);
    bready = 0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input int rhold);
    logic [31:0] exp, first;
    @(negedge clk);
    araddr = a; arvalid = 1; rready = (rhold == 0);
    do @(negedge clk); while (!arready);
    exp = exp_rd(a);
    @(posedge clk);
    #1 arvalid = 0;
    @(negedge clk);
    chk("R3 rvalid", {31'd0, rvalid}, 32'd1);
    chk("R3 rresp", {30'd0, rresp}, 32'd0);
    chk(req, rdata, exp);
    first = rdata;
    for (int i = 0; i < rhold; i++) begin
      @(negedge clk);
      chk("R3 rvalid held", {31'd0, rvalid}, 32'd1);
      chk("R3 rdata stable", rdata, first);
    end
    rready = 1;
    @(negedge clk);
    chk("R3 rvalid drop", {31'd0, rvalid}, 32'd0);
    rready = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); frame_start = 1;
    @(posedge clk); m_qo = m_qual; m_ro = m_rint;
    @(negedge clk); frame_start = 0;
  endtask

  task automatic pulse_end(input logic [31:0] bytes);
    @(negedge clk); frame_end = 1; frame_bytes = bytes;
    @(posedge clk); m_done = 1; m_cnt++; m_size = bytes;
    @(negedge clk); frame_end = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 awready", {31'd0, awready}, 0);
    chk("R1 bvalid", {31'd0, bvalid}, 0);
    chk("R1 arready", {31'd0, arready}, 0);
    chk("R1 rvalid", {31'd0, rvalid}, 0);
    rd("R1 ctrl", 8'h00, 0);
    rd("R1 status", 8'h04, 0);
    rd("R1 count", 8'h08, 0);
    rd("R1 quality", 8'h0C, 0);
    rd("R1 restart", 8'h10, 0);
    rd("R1 size", 8'h14, 0);

    // R4 enable
    wr(8'h00, 32'h1, 0, 0, 0);
    rd("R4 ctrl readback", 8'h00, 0);

    // R8 / R9 quality
    wr(8'h0C, 32'd50, 0, 0, 0);
    rd("R8 quality 50", 8'h0C, 0);
    repeat (3) @(negedge clk);
    pulse_start();
    wr(8'h0C, 32'd0, 0, 0, 0);       rd("R8 quality 0 to 1", 8'h0C, 0);
    wr(8'h0C, 32'd101, 0, 0, 0);     rd("R8 quality 101 to 100", 8'h0C, 0);
    wr(8'h0C, 32'hFFFF_FFFF, 0, 0, 0); rd("R8 quality max to 100", 8'h0C, 0);
    wr(8'h0C, 32'd1, 0, 0, 0);       rd("R8 quality 1", 8'h0C, 0);
    wr(8'h0C, 32'd100, 0, 0, 0);     rd("R8 quality 100", 8'h0C, 0);

    // R10 restart
    wr(8'h10, 32'h0001_2345, 0, 0, 0);
    rd("R10 restart truncated", 8'h10, 0);
    pulse_start();

    // R6 frame end
    pulse_end(32'd1234);
    rd("R6 status done", 8'h04, 0);
    rd("R6 count", 8'h08, 0);
    rd("R6 size", 8'h14, 0);

    // R7 busy and W1C
    core_busy = 1;
    rd("R7 busy live", 8'h04, 0);
    wr(8'h04, 32'h1, 0, 0, 0);  rd("R7 busy write ignored", 8'h04, 0);
    wr(8'h04, 32'h0, 0, 0, 0);  rd("R7 write 0 keeps done", 8'h04, 0);
    wr(8'h04, 32'h2, 0, 0, 0);  rd("R7 W1C clears done", 8'h04, 0);
    core_busy = 0;

    // R12 read-only registers
    pulse_end(32'd777);
    wr(8'h08, 32'h55, 0, 0, 0); rd("R12 count write ignored", 8'h08, 0);
    wr(8'h14, 32'h66, 0, 0, 0); rd("R12 size write ignored", 8'h14, 0);

    // R7 set wins over simultaneous clear
    wr(8'h04, 32'h2, 1, 32'd4321, 0);
    rd("R7 set beats clear", 8'h04, 0);
    rd("R7 count after collision", 8'h08, 0);
    rd("R7 size after collision", 8'h14, 0);

    // R11 unmapped
    wr(8'h18, 32'hFFFF_FFFF, 0, 0, 0);
    wr(8'h40, 32'h0, 0, 0, 0);
    rd("R11 unmapped 0x18", 8'h18, 0);
    rd("R11 unmapped 0x40", 8'h40, 0);
    rd("R11 quality intact", 8'h0C, 0);
    rd("R11 ctrl intact", 8'h00, 0);

    // R5 soft reset
    wr(8'h00, 32'h3, 0, 0, 0);
    rd("R5 ctrl bit1 reads 0", 8'h00, 0);
    rd("R5 status cleared", 8'h04, 0);
    rd("R5 count cleared", 8'h08, 0);
    rd("R5 size cleared", 8'h14, 0);
    rd("R5 quality kept", 8'h0C, 0);
    rd("R5 restart kept", 8'h10, 0);

    // R2 / R3 response stalls
    wr(8'h10, 32'h0000_0007, 0, 0, 3);
    rd("R3 stalled read", 8'h10, 4);
    pulse_start();
    wr(8'h00, 32'h0, 0, 0, 2);
    rd("R4 enable cleared", 8'h00, 0);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule